// File: doc/BRIEF.md
# Enclave Thread Gate Controller

This block is the per-processor sequencer that moves a thread into and out of an isolated execution region. Three request codes arrive on one request port. An enter request names a thread slot. A resume request names a slot whose context was saved earlier. An exit request leaves the region synchronously. A separate event input carries interrupts and exceptions. Each thread slot comes from a table driven from outside. The table gives a valid bit, an entry address and a stack base for each slot. Inside the block, each slot also has a busy flag and a saved-context flag.

When an event arrives while a thread is inside, the controller spends one cycle per context word copying the live register context into that thread's save slot. It then drops back outside and jumps to the return address the caller gave on entry. A later resume reloads the saved words and continues from the saved instruction address, not from the entry point. A privileged read port can inspect the saved words, but only while enclave mode is clear. Because every slot holds exactly one thread, the slot count caps how many threads can be inside or suspended at once.

Top module: `encl_gate`

## Requirements
- R1: After reset, enclave mode is clear, no slot is busy, and the jump, flush, context-load, event-out and response-valid strobes are all low.
- R2: An enter (op code 1) while outside, on a valid slot that is not busy, is accepted. On the next cycle the block pulses the flush strobe and the jump strobe for one cycle, drives that slot's entry address and stack base, sets enclave mode and the slot's busy bit, and reports response code 1.
- R3: An enter or resume naming a slot whose valid bit is low gets response code 2 and changes neither the mode nor any slot flag.
- R4: An enter on a busy slot gets response code 3, with no flush and no mode change.
- R5: An exit (op code 2) while inside, with no event in the same cycle, gets code 1 on the next cycle. That cycle also pulses the jump strobe to the return address captured at entry or resume, clears enclave mode and clears the active slot's busy bit.
- R6: An event while inside starts a save that lasts exactly CTX_WORDS cycles, with enclave mode held high. Each cycle stores one word of the live context into the active slot. At the end the block pulses the event-out strobe and jumps to the captured return address, clears enclave mode, sets the saved flag and leaves the slot busy.
- R7: A resume (op code 3) while outside, on a valid slot with a saved context, gets code 1. On the next cycle it pulses flush, jump and context-load. The jump address is the low bits of saved word 0, the stack output is the low bits of saved word 1, and the restore bus carries all saved words. It also sets enclave mode and clears the saved flag.
- R8: A resume on a valid slot without a saved context gets code 4 and has no other effect.
- R9: An event while outside produces an event-out pulse on the next cycle. It leaves the mode, the busy bits and every save slot untouched.
- R10: An exit while outside, an enter or resume while inside, and any request arriving together with an event while inside all get code 5. The request has no effect, and the event still starts the save.
- R11: A privileged read of (slot, word) returns the saved word with the ok flag set on the next cycle when enclave mode is clear. When enclave mode is set, it returns zero with ok low.
- R12: Slots are tracked independently. Once every slot holds a thread, whether inside or suspended, every enter is refused with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 none, 1 enter, 2 exit, 3 resume |
| req_slot_i | input | SLOT_W | Thread slot named by enter or resume |
| req_addr_i | input | ADDR_W | Caller return address captured on enter or resume |
| evt_i | input | 1 | Interrupt or exception event |
| slot_valid_i | input | NUM_SLOTS | Valid bit for each thread slot |
| slot_entry_i | input | NUM_SLOTS*ADDR_W | Entry address for each slot |
| slot_stack_i | input | NUM_SLOTS*ADDR_W | Stack base for each slot |
| ctx_live_i | input | CTX_WORDS*DATA_W | Live register context; word 0 is the instruction address, word 1 the stack pointer |
| ctx_rest_o | output | CTX_WORDS*DATA_W | Context reloaded by a resume |
| ctx_load_o | output | 1 | Pulse: restore bus is valid |
| jump_o | output | 1 | Pulse: redirect execution to jump_addr_o |
| jump_addr_o | output | ADDR_W | Redirect address |
| stack_ptr_o | output | ADDR_W | Stack pointer given on enter or resume |
| tlb_flush_o | output | 1 | Pulse: flush address translations |
| enc_mode_o | output | 1 | Enclave mode flag |
| evt_out_o | output | 1 | Pulse: event handed to the outside handler |
| rsp_valid_o | output | 1 | Pulse: response code valid |
| rsp_code_o | output | 3 | 1 ok, 2 bad slot, 3 busy, 4 no context, 5 wrong state |
| slot_busy_o | output | NUM_SLOTS | Busy bit for each slot |
| peek_en_i | input | 1 | Privileged read strobe |
| peek_slot_i | input | SLOT_W | Slot to read |
| peek_word_i | input | WORD_W | Context word to read |
| peek_data_o | output | DATA_W | Read result |
| peek_ok_o | output | 1 | Read was permitted |

## Verification
The response code, the flush, jump and context-load strobes, the mode flag, the busy bits and the privileged read result all appear one cycle after the request edge. For an event taken inside, the mode drop, the event-out pulse and the return jump appear CTX_WORDS edges after the edge that samples the event. The bench drives inputs on the falling edge and checks each result on the falling edge after the clock edge where it is due. During a save it checks at every intermediate falling edge that the mode is still held. A bench-side model of the slot flags and saved words supplies every expected value.

// File: rtl/encl_pkg.sv
package encl_pkg;
    typedef enum logic [1:0] {
        ST_OUT  = 2'd0,
        ST_IN   = 2'd1,
        ST_SAVE = 2'd2
    } gate_state_e;

    localparam logic [1:0] OP_NONE   = 2'd0;
    localparam logic [1:0] OP_ENTER  = 2'd1;
    localparam logic [1:0] OP_EXIT   = 2'd2;
    localparam logic [1:0] OP_RESUME = 2'd3;

    localparam logic [2:0] RS_NONE    = 3'd0;
    localparam logic [2:0] RS_OK      = 3'd1;
    localparam logic [2:0] RS_BADSLOT = 3'd2;
    localparam logic [2:0] RS_BUSY    = 3'd3;
    localparam logic [2:0] RS_NOCTX   = 3'd4;
    localparam logic [2:0] RS_ORDER   = 3'd5;
endpackage

// File: rtl/encl_slot_tbl.sv
module encl_slot_tbl #(
    parameter int NUM_SLOTS = 4,
    parameter int CTX_WORDS = 4,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SLOT_W-1:0]                 flag_slot_i,
    input  logic                              busy_set_i,
    input  logic                              busy_clr_i,
    input  logic                              saved_set_i,
    input  logic                              saved_clr_i,
    input  logic                              wr_en_i,
    input  logic [SLOT_W-1:0]                 wr_slot_i,
    input  logic [WORD_W-1:0]                 wr_word_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    output logic [NUM_SLOTS-1:0]              busy_o,
    output logic [NUM_SLOTS-1:0]              saved_o,
    output logic [NUM_SLOTS*CTX_WORDS*DATA_W-1:0] save_flat_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] busy;
        logic [NUM_SLOTS-1:0] saved;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (busy_set_i)  fl_d.busy[flag_slot_i]  = 1'b1;
        if (busy_clr_i)  fl_d.busy[flag_slot_i]  = 1'b0;
        if (saved_set_i) fl_d.saved[flag_slot_i] = 1'b1;
        if (saved_clr_i) fl_d.saved[flag_slot_i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign busy_o  = fl_q.busy;
    assign saved_o = fl_q.saved;

    // One register per (slot, word); only the addressed word loads.
    for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
        for (genvar gw = 0; gw < CTX_WORDS; gw++) begin : g_word
            logic [DATA_W-1:0] w_d, w_q;
            always_comb begin
                w_d = w_q;
                if (wr_en_i && (wr_slot_i == SLOT_W'(gs)) && (wr_word_i == WORD_W'(gw)))
                    w_d = wr_data_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) w_q <= '0;
                else        w_q <= w_d;
            end
            assign save_flat_o[(gs*CTX_WORDS+gw)*DATA_W +: DATA_W] = w_q;
        end
    end
endmodule

// File: rtl/encl_peek.sv
module encl_peek #(
    parameter int NUM_SLOTS = 4,
    parameter int CTX_WORDS = 4,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   rd_en_i,
    input  logic [SLOT_W-1:0]                      rd_slot_i,
    input  logic [WORD_W-1:0]                      rd_word_i,
    input  logic                                   lock_i,
    input  logic [NUM_SLOTS*CTX_WORDS*DATA_W-1:0]  save_flat_i,
    output logic [DATA_W-1:0]                      data_o,
    output logic                                   ok_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ok;
    } peek_t;

    peek_t p_d, p_q;
    logic  in_range;

    assign in_range = (int'(rd_slot_i) < NUM_SLOTS) && (int'(rd_word_i) < CTX_WORDS);

    always_comb begin
        p_d = '0;
        if (rd_en_i && !lock_i && in_range) begin
            p_d.ok   = 1'b1;
            p_d.data = save_flat_i[(int'(rd_slot_i)*CTX_WORDS + int'(rd_word_i))*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign data_o = p_q.data;
    assign ok_o   = p_q.ok;
endmodule

// File: rtl/encl_fsm.sv
module encl_fsm
    import encl_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CTX_WORDS = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1,
    localparam int CTX_W    = CTX_WORDS * DATA_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid_i,
    input  logic [1:0]                             req_op_i,
    input  logic [SLOT_W-1:0]                      req_slot_i,
    input  logic [ADDR_W-1:0]                      req_addr_i,
    input  logic                                   evt_i,
    input  logic [NUM_SLOTS-1:0]                   slot_valid_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]            slot_entry_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]            slot_stack_i,
    input  logic [CTX_W-1:0]                       ctx_live_i,
    input  logic [NUM_SLOTS-1:0]                   busy_i,
    input  logic [NUM_SLOTS-1:0]                   saved_i,
    input  logic [NUM_SLOTS*CTX_W-1:0]             save_flat_i,
    output gate_state_e                            state_o,
    output logic [SLOT_W-1:0]                      flag_slot_o,
    output logic                                   busy_set_o,
    output logic                                   busy_clr_o,
    output logic                                   saved_set_o,
    output logic                                   saved_clr_o,
    output logic                                   wr_en_o,
    output logic [SLOT_W-1:0]                      wr_slot_o,
    output logic [WORD_W-1:0]                      wr_word_o,
    output logic [DATA_W-1:0]                      wr_data_o,
    output logic [ADDR_W-1:0]                      jump_addr_o,
    output logic                                   jump_o,
    output logic [ADDR_W-1:0]                      stack_ptr_o,
    output logic                                   tlb_flush_o,
    output logic [CTX_W-1:0]                       ctx_rest_o,
    output logic                                   ctx_load_o,
    output logic                                   evt_out_o,
    output logic                                   rsp_valid_o,
    output logic [2:0]                             rsp_code_o
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(CTX_WORDS - 1);

    typedef struct packed {
        gate_state_e       st;
        logic [SLOT_W-1:0] act;
        logic [WORD_W-1:0] cnt;
        logic [ADDR_W-1:0] ret;
        logic [ADDR_W-1:0] jaddr;
        logic [ADDR_W-1:0] sp;
        logic [CTX_W-1:0]  rest;
        logic              jump;
        logic              flush;
        logic              ctx_ld;
        logic              evt_out;
        logic              rsp_v;
        logic [2:0]        rsp;
    } fsm_t;

    fsm_t q, n;

    logic              slot_ok;
    logic              has_req;
    logic [CTX_W-1:0]  slot_ctx;
    logic [DATA_W-1:0] saved_w0;
    logic [DATA_W-1:0] saved_w1;

    assign slot_ok  = (int'(req_slot_i) < NUM_SLOTS) && slot_valid_i[req_slot_i];
    assign has_req  = req_valid_i && (req_op_i != OP_NONE);
    assign slot_ctx = save_flat_i[int'(req_slot_i)*CTX_W +: CTX_W];
    assign saved_w0 = slot_ctx[0 +: DATA_W];
    assign saved_w1 = slot_ctx[DATA_W +: DATA_W];

    always_comb begin
        n         = q;
        n.jump    = 1'b0;
        n.flush   = 1'b0;
        n.ctx_ld  = 1'b0;
        n.evt_out = 1'b0;
        n.rsp_v   = has_req;
        n.rsp     = RS_NONE;

        flag_slot_o = req_slot_i;
        busy_set_o  = 1'b0;
        busy_clr_o  = 1'b0;
        saved_set_o = 1'b0;
        saved_clr_o = 1'b0;
        wr_en_o     = 1'b0;
        wr_slot_o   = q.act;
        wr_word_o   = q.cnt;
        wr_data_o   = ctx_live_i[int'(q.cnt)*DATA_W +: DATA_W];

        unique case (q.st)
            ST_OUT: begin
                if (evt_i) n.evt_out = 1'b1;
                if (has_req) begin
                    unique case (req_op_i)
                        OP_ENTER: begin
                            if (!slot_ok)                 n.rsp = RS_BADSLOT;
                            else if (busy_i[req_slot_i])  n.rsp = RS_BUSY;
                            else begin
                                n.rsp      = RS_OK;
                                n.st       = ST_IN;
                                n.act      = req_slot_i;
                                n.ret      = req_addr_i;
                                n.jaddr    = slot_entry_i[int'(req_slot_i)*ADDR_W +: ADDR_W];
                                n.sp       = slot_stack_i[int'(req_slot_i)*ADDR_W +: ADDR_W];
                                n.jump     = 1'b1;
                                n.flush    = 1'b1;
                                busy_set_o = 1'b1;
                            end
                        end
                        OP_RESUME: begin
                            if (!slot_ok)                  n.rsp = RS_BADSLOT;
                            else if (!saved_i[req_slot_i]) n.rsp = RS_NOCTX;
                            else begin
                                n.rsp       = RS_OK;
                                n.st        = ST_IN;
                                n.act       = req_slot_i;
                                n.ret       = req_addr_i;
                                n.jaddr     = saved_w0[ADDR_W-1:0];
                                n.sp        = saved_w1[ADDR_W-1:0];
                                n.rest      = slot_ctx;
                                n.jump      = 1'b1;
                                n.flush     = 1'b1;
                                n.ctx_ld    = 1'b1;
                                saved_clr_o = 1'b1;
                            end
                        end
                        default: n.rsp = RS_ORDER;
                    endcase
                end
            end
            ST_IN: begin
                if (evt_i) begin
                    n.st  = ST_SAVE;
                    n.cnt = '0;
                    if (has_req) n.rsp = RS_ORDER;
                end else if (has_req) begin
                    if (req_op_i == OP_EXIT) begin
                        n.rsp       = RS_OK;
                        n.st        = ST_OUT;
                        n.jaddr     = q.ret;
                        n.jump      = 1'b1;
                        flag_slot_o = q.act;
                        busy_clr_o  = 1'b1;
                    end else begin
                        n.rsp = RS_ORDER;
                    end
                end
            end
            ST_SAVE: begin
                wr_en_o = 1'b1;
                if (has_req) n.rsp = RS_ORDER;
                if (q.cnt == LAST_WORD) begin
                    n.st        = ST_OUT;
                    n.cnt       = '0;
                    n.jaddr     = q.ret;
                    n.jump      = 1'b1;
                    n.evt_out   = 1'b1;
                    flag_slot_o = q.act;
                    saved_set_o = 1'b1;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            default: n.st = ST_OUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign state_o     = q.st;
    assign jump_addr_o = q.jaddr;
    assign jump_o      = q.jump;
    assign stack_ptr_o = q.sp;
    assign tlb_flush_o = q.flush;
    assign ctx_rest_o  = q.rest;
    assign ctx_load_o  = q.ctx_ld;
    assign evt_out_o   = q.evt_out;
    assign rsp_valid_o = q.rsp_v;
    assign rsp_code_o  = q.rsp;
endmodule

// File: rtl/encl_gate.sv
module encl_gate
    import encl_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CTX_WORDS = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WORD_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid_i,
    input  logic [1:0]                      req_op_i,
    input  logic [SLOT_W-1:0]               req_slot_i,
    input  logic [ADDR_W-1:0]               req_addr_i,
    input  logic                            evt_i,
    input  logic [NUM_SLOTS-1:0]            slot_valid_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]     slot_entry_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]     slot_stack_i,
    input  logic [CTX_WORDS*DATA_W-1:0]     ctx_live_i,
    output logic [CTX_WORDS*DATA_W-1:0]     ctx_rest_o,
    output logic                            ctx_load_o,
    output logic                            jump_o,
    output logic [ADDR_W-1:0]               jump_addr_o,
    output logic [ADDR_W-1:0]               stack_ptr_o,
    output logic                            tlb_flush_o,
    output logic                            enc_mode_o,
    output logic                            evt_out_o,
    output logic                            rsp_valid_o,
    output logic [2:0]                      rsp_code_o,
    output logic [NUM_SLOTS-1:0]            slot_busy_o,
    input  logic                            peek_en_i,
    input  logic [SLOT_W-1:0]               peek_slot_i,
    input  logic [WORD_W-1:0]               peek_word_i,
    output logic [DATA_W-1:0]               peek_data_o,
    output logic                            peek_ok_o
);
    gate_state_e                            fsm_st;
    logic [SLOT_W-1:0]                      flag_slot;
    logic                                   busy_set, busy_clr, saved_set, saved_clr;
    logic                                   wr_en;
    logic [SLOT_W-1:0]                      wr_slot;
    logic [WORD_W-1:0]                      wr_word;
    logic [DATA_W-1:0]                      wr_data;
    logic [NUM_SLOTS-1:0]                   saved;
    logic [NUM_SLOTS*CTX_WORDS*DATA_W-1:0]  save_flat;

    assign enc_mode_o = (fsm_st != ST_OUT);

    encl_fsm #(
        .NUM_SLOTS(NUM_SLOTS), .CTX_WORDS(CTX_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_op_i     (req_op_i),
        .req_slot_i   (req_slot_i),
        .req_addr_i   (req_addr_i),
        .evt_i        (evt_i),
        .slot_valid_i (slot_valid_i),
        .slot_entry_i (slot_entry_i),
        .slot_stack_i (slot_stack_i),
        .ctx_live_i   (ctx_live_i),
        .busy_i       (slot_busy_o),
        .saved_i      (saved),
        .save_flat_i  (save_flat),
        .state_o      (fsm_st),
        .flag_slot_o  (flag_slot),
        .busy_set_o   (busy_set),
        .busy_clr_o   (busy_clr),
        .saved_set_o  (saved_set),
        .saved_clr_o  (saved_clr),
        .wr_en_o      (wr_en),
        .wr_slot_o    (wr_slot),
        .wr_word_o    (wr_word),
        .wr_data_o    (wr_data),
        .jump_addr_o  (jump_addr_o),
        .jump_o       (jump_o),
        .stack_ptr_o  (stack_ptr_o),
        .tlb_flush_o  (tlb_flush_o),
        .ctx_rest_o   (ctx_rest_o),
        .ctx_load_o   (ctx_load_o),
        .evt_out_o    (evt_out_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_code_o   (rsp_code_o)
    );

    encl_slot_tbl #(
        .NUM_SLOTS(NUM_SLOTS), .CTX_WORDS(CTX_WORDS), .DATA_W(DATA_W)
    ) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_slot_i (flag_slot),
        .busy_set_i  (busy_set),
        .busy_clr_i  (busy_clr),
        .saved_set_i (saved_set),
        .saved_clr_i (saved_clr),
        .wr_en_i     (wr_en),
        .wr_slot_i   (wr_slot),
        .wr_word_i   (wr_word),
        .wr_data_i   (wr_data),
        .busy_o      (slot_busy_o),
        .saved_o     (saved),
        .save_flat_o (save_flat)
    );

    encl_peek #(
        .NUM_SLOTS(NUM_SLOTS), .CTX_WORDS(CTX_WORDS), .DATA_W(DATA_W)
    ) u_peek (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (peek_en_i),
        .rd_slot_i   (peek_slot_i),
        .rd_word_i   (peek_word_i),
        .lock_i      (enc_mode_o),
        .save_flat_i (save_flat),
        .data_o      (peek_data_o),
        .ok_o        (peek_ok_o)
    );
endmodule

// File: rtl/encl_gate_chk.sv
module encl_gate_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int CTX_WORDS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid_i,
    input logic [1:0]                  req_op_i,
    input logic [SLOT_W-1:0]           req_slot_i,
    input logic                        evt_i,
    input logic [NUM_SLOTS-1:0]        slot_valid_i,
    input logic [NUM_SLOTS*ADDR_W-1:0] slot_entry_i,
    input logic [1:0]                  st,
    input logic                        enc_mode_o,
    input logic                        tlb_flush_o,
    input logic                        jump_o,
    input logic [ADDR_W-1:0]           jump_addr_o,
    input logic                        evt_out_o,
    input logic                        rsp_valid_o,
    input logic [2:0]                  rsp_code_o,
    input logic [NUM_SLOTS-1:0]        slot_busy_o,
    input logic                        peek_en_i,
    input logic [DATA_W-1:0]           peek_data_o,
    input logic                        peek_ok_o
);
    int unsigned sv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            sv_cnt <= 0;
        else if (st == 2'd2)   sv_cnt <= sv_cnt + 1;
        else                   sv_cnt <= 0;
    end

    a_r2_enter_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'd1 && st == 2'd0 &&
         slot_valid_i[req_slot_i] && !slot_busy_o[req_slot_i])
        |=> (enc_mode_o && tlb_flush_o && jump_o && rsp_code_o == 3'd1 &&
             jump_addr_o == $past(slot_entry_i[int'(req_slot_i)*ADDR_W +: ADDR_W])));

    a_r2_flush_with_jump: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> (jump_o && enc_mode_o));

    a_r4_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'd1 && st == 2'd0 &&
         slot_valid_i[req_slot_i] && slot_busy_o[req_slot_i])
        |=> (rsp_valid_o && rsp_code_o == 3'd3 && !enc_mode_o && !tlb_flush_o));

    a_r5_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'd2 && st == 2'd1 && !evt_i)
        |=> (!enc_mode_o && jump_o && rsp_code_o == 3'd1));

    a_r6_save_start: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && st == 2'd1) |=> (st == 2'd2 && enc_mode_o));

    a_r6_save_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2) |-> (sv_cnt < CTX_WORDS));

    a_r6_save_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2 && sv_cnt == CTX_WORDS - 1) |=> (st == 2'd0 && evt_out_o && jump_o));

    a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && st == 2'd0 && !req_valid_i)
        |=> (evt_out_o && !enc_mode_o && $stable(slot_busy_o)));

    a_r10_exit_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'd2 && st == 2'd0)
        |=> (rsp_valid_o && rsp_code_o == 3'd5 && !jump_o));

    a_r11_peek_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_en_i && enc_mode_o) |=> (!peek_ok_o && peek_data_o == '0));
endmodule

bind encl_gate encl_gate_chk #(
    .NUM_SLOTS(NUM_SLOTS), .CTX_WORDS(CTX_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_op_i     (req_op_i),
    .req_slot_i   (req_slot_i),
    .evt_i        (evt_i),
    .slot_valid_i (slot_valid_i),
    .slot_entry_i (slot_entry_i),
    .st           (fsm_st),
    .enc_mode_o   (enc_mode_o),
    .tlb_flush_o  (tlb_flush_o),
    .jump_o       (jump_o),
    .jump_addr_o  (jump_addr_o),
    .evt_out_o    (evt_out_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_code_o   (rsp_code_o),
    .slot_busy_o  (slot_busy_o),
    .peek_en_i    (peek_en_i),
    .peek_data_o  (peek_data_o),
    .peek_ok_o    (peek_ok_o)
);

// File: tb/encl_gate_bench.sv
`timescale 1ns/1ps
module encl_gate_bench;
    localparam int NS = 4;
    localparam int CW = 4;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int SW = 2;
    localparam int WW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [SW-1:0]     req_slot = '0;
    logic [AW-1:0]     req_addr = '0;
    logic              evt = 1'b0;
    logic [NS-1:0]     vld = '0;
    logic [NS*AW-1:0]  ent = '0;
    logic [NS*AW-1:0]  stk = '0;
    logic [CW*DW-1:0]  ctx_live = '0;
    logic [CW*DW-1:0]  ctx_rest;
    logic              ctx_load, jump, tlb_flush, enc_mode, evt_out, rsp_valid;
    logic [AW-1:0]     jump_addr, stack_ptr;
    logic [2:0]        rsp_code;
    logic [NS-1:0]     busy;
    logic              peek_en = 1'b0;
    logic [SW-1:0]     peek_slot = '0;
    logic [WW-1:0]     peek_word = '0;
    logic [DW-1:0]     peek_data;
    logic              peek_ok;

    always #4 clk = ~clk;

    encl_gate #(.NUM_SLOTS(NS), .CTX_WORDS(CW), .DATA_W(DW), .ADDR_W(AW)) u_encl_gate (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_slot_i(req_slot), .req_addr_i(req_addr), .evt_i(evt),
        .slot_valid_i(vld), .slot_entry_i(ent), .slot_stack_i(stk),
        .ctx_live_i(ctx_live), .ctx_rest_o(ctx_rest), .ctx_load_o(ctx_load),
        .jump_o(jump), .jump_addr_o(jump_addr), .stack_ptr_o(stack_ptr),
        .tlb_flush_o(tlb_flush), .enc_mode_o(enc_mode), .evt_out_o(evt_out),
        .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .slot_busy_o(busy),
        .peek_en_i(peek_en), .peek_slot_i(peek_slot), .peek_word_i(peek_word),
        .peek_data_o(peek_data), .peek_ok_o(peek_ok)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Reference model
    bit [NS-1:0]   m_busy = '0;
    bit [NS-1:0]   m_saved = '0;
    logic [DW-1:0] m_save [NS][CW];
    bit            m_in = 1'b0;
    int            m_act = 0;
    logic [AW-1:0] m_ret = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string code_tag(input int rc);
        case (rc)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R8";
            5: return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic step(input int op, input int s, input logic [AW-1:0] a, input bit ev,
                        input bit pk, input int ps, input int pw);
        int            rc = 0;
        bit            e_flush = 0, e_jump = 0, e_sp = 0, e_ctx = 0, e_evo = 0, to_save = 0;
        logic [AW-1:0] e_ja = '0, e_spv = '0;
        logic [CW*DW-1:0] e_rest = '0;
        bit            e_pok;
        logic [DW-1:0] e_pdat;
        string         tg;
        e_pok  = pk && !m_in;
        e_pdat = e_pok ? m_save[ps][pw] : '0;
        if (!m_in) begin
            if (ev) e_evo = 1;
            case (op)
                1: if (!vld[s]) rc = 2;
                   else if (m_busy[s]) rc = 3;
                   else begin
                       rc = 1; e_flush = 1; e_jump = 1; e_sp = 1;
                       e_ja = ent[s*AW +: AW]; e_spv = stk[s*AW +: AW];
                       m_busy[s] = 1; m_in = 1; m_act = s; m_ret = a;
                   end
                2: rc = 5;
                3: if (!vld[s]) rc = 2;
                   else if (!m_saved[s]) rc = 4;
                   else begin
                       rc = 1; e_flush = 1; e_jump = 1; e_sp = 1; e_ctx = 1;
                       e_ja = m_save[s][0][AW-1:0]; e_spv = m_save[s][1][AW-1:0];
                       for (int w = 0; w < CW; w++) e_rest[w*DW +: DW] = m_save[s][w];
                       m_saved[s] = 0; m_in = 1; m_act = s; m_ret = a;
                   end
                default: rc = 0;
            endcase
            tg = (op == 3 && rc == 1) ? "R7" : (op == 2 && rc == 1) ? "R5" : code_tag(rc);
            if (op == 0 && ev) tg = "R9";
        end else begin
            if (ev) begin
                to_save = 1;
                if (op != 0) rc = 5;
                tg = "R6";
            end else if (op == 2) begin
                rc = 1; e_jump = 1; e_ja = m_ret;
                m_busy[m_act] = 0; m_in = 0;
                tg = "R5";
            end else if (op != 0) begin
                rc = 5; tg = "R10";
            end else tg = "R2";
        end

        req_valid = (op != 0); req_op = 2'(op); req_slot = SW'(s); req_addr = a; evt = ev;
        peek_en = pk; peek_slot = SW'(ps); peek_word = WW'(pw);
        cycle();
        req_valid = 0; req_op = '0; evt = 0; peek_en = 0;

        chk({tg, " rsp_valid"}, 64'(rsp_valid), 64'(op != 0));
        if (op != 0) chk({tg, " rsp_code"}, 64'(rsp_code), 64'(rc));
        chk({tg, " flush"}, 64'(tlb_flush), 64'(e_flush));
        chk({tg, " jump"}, 64'(jump), 64'(e_jump));
        if (e_jump) chk({tg, " jump_addr"}, 64'(jump_addr), 64'(e_ja));
        if (e_sp) chk({tg, " stack_ptr"}, 64'(stack_ptr), 64'(e_spv));
        chk({tg, " ctx_load"}, 64'(ctx_load), 64'(e_ctx));
        if (e_ctx)
            for (int w = 0; w < CW; w++)
                chk("R7 restore word", 64'(ctx_rest[w*DW +: DW]), 64'(e_rest[w*DW +: DW]));
        chk({tg, " evt_out"}, 64'(evt_out), 64'(e_evo));
        chk({tg, " mode"}, 64'(enc_mode), 64'(m_in));
        chk({tg, " busy"}, 64'(busy), 64'(m_busy));
        chk("R11 peek ok", 64'(peek_ok), 64'(e_pok));
        chk("R11 peek data", 64'(peek_data), 64'(e_pdat));

        if (to_save) begin
            for (int i = 1; i <= CW; i++) begin
                cycle();
                if (i < CW) begin
                    chk("R6 mode held while saving", 64'(enc_mode), 64'd1);
                    chk("R6 no early evt_out", 64'(evt_out), 64'd0);
                end else begin
                    chk("R6 mode dropped", 64'(enc_mode), 64'd0);
                    chk("R6 evt_out", 64'(evt_out), 64'd1);
                    chk("R6 jump", 64'(jump), 64'd1);
                    chk("R6 return addr", 64'(jump_addr), 64'(m_ret));
                end
            end
            for (int w = 0; w < CW; w++) m_save[m_act][w] = ctx_live[w*DW +: DW];
            m_saved[m_act] = 1;
            m_in = 0;
            chk("R6 slot stays busy", 64'(busy), 64'(m_busy));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < CW; w++) m_save[s][w] = '0;
        for (int s = 0; s < NS; s++) begin
            ent[s*AW +: AW] = AW'($urandom);
            stk[s*AW +: AW] = AW'($urandom);
        end
        for (int w = 0; w < CW; w++) ctx_live[w*DW +: DW] = $urandom;
        vld = 4'b0111;
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R1: reset state
        chk("R1 mode", 64'(enc_mode), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 strobes", 64'({jump, tlb_flush, ctx_load, evt_out, rsp_valid}), 64'd0);

        step(1, 3, 16'h1111, 0, 0, 0, 0);          // R3 invalid slot
        step(3, 3, 16'h1111, 0, 0, 0, 0);          // R3 resume on invalid slot
        step(1, 0, 16'h2222, 0, 0, 0, 0);          // R2 enter
        step(2, 0, 16'h0000, 0, 0, 0, 0);          // R5 exit
        step(1, 1, 16'h3333, 0, 0, 0, 0);          // R2 enter slot 1
        step(0, 0, 16'h0000, 1, 1, 1, 2);          // R6 async save, R11 locked read
        step(0, 0, 16'h0000, 0, 1, 1, 2);          // R11 read outside
        step(1, 1, 16'h4444, 0, 0, 0, 0);          // R4 busy (suspended)
        step(3, 1, 16'h5555, 0, 0, 0, 0);          // R7 resume
        step(0, 0, 16'h0000, 0, 1, 1, 0);          // R11 locked while inside
        step(3, 2, 16'h0000, 0, 0, 0, 0);          // R10 resume inside
        step(2, 0, 16'h0000, 0, 0, 0, 0);          // R5 exit to 5555
        step(3, 0, 16'h0000, 0, 0, 0, 0);          // R8 no saved context
        step(0, 0, 16'h0000, 1, 0, 0, 0);          // R9 event outside
        step(2, 0, 16'h0000, 0, 0, 0, 0);          // R10 exit outside
        step(1, 2, 16'h6666, 0, 0, 0, 0);
        step(1, 0, 16'h0000, 0, 0, 0, 0);          // R10 enter inside
        step(2, 0, 16'h0000, 1, 0, 0, 0);          // R10 exit with event: event wins

        // R12: fill every slot, then every enter is refused
        vld = '1;
        for (int s = 0; s < NS; s++)
            if (!m_busy[s]) begin
                step(1, s, AW'(16'h7000 + s), 0, 0, 0, 0);
                step(0, 0, 16'h0000, 1, 0, 0, 0);
            end
        for (int s = 0; s < NS; s++) begin
            step(1, s, 16'h0000, 0, 0, 0, 0);
            chk("R12 full table refuses enter", 64'(rsp_code), 64'd3);
        end
        for (int s = 0; s < NS; s++) begin
            step(3, s, 16'h0000, 0, 0, 0, 0);
            step(2, 0, 16'h0000, 0, 0, 0, 0);
        end

        // Constrained random phase
        for (int it = 0; it < 400; it++) begin
            int op, s, ps, pw;
            bit ev, pk;
            op = int'($urandom_range(0, 3));
            s  = int'($urandom_range(0, NS - 1));
            ev = ($urandom_range(0, 4) == 0);
            pk = $urandom_range(0, 1) == 1;
            ps = int'($urandom_range(0, NS - 1));
            pw = int'($urandom_range(0, CW - 1));
            if (!m_in && ($urandom_range(0, 9) == 0)) vld[3] = ~vld[3];
            for (int w = 0; w < CW; w++) ctx_live[w*DW +: DW] = $urandom;
            step(op, s, AW'($urandom), ev, pk, ps, pw);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule